// File: doc/BRIEF.md
# Channel Mode and Reset Controller

This block is the control register file of a multi-channel storage host adapter. Each channel has its own address window. The window holds a 64-bit packet base pointer, a slot-size exponent and four 16-bit FIFO threshold values. It also holds two control bytes and a command port. Together these decide whether the channel is driven by direct register access or by the packet engine. A small global window holds a chip-wide reset, an interrupt enable and a per-channel PHY detection enable. It also reports whether the host bus is 64 bits wide.

Software writes the run command to a channel's command port to hand that channel to the packet engine. The packet engine hands the channel back by raising a completion report. Software can also take the channel back at any time by setting the register-mode bit. The reset and error-clear bits are never stored. Each produces a one-cycle strobe towards the datapath it controls, and each always reads back as zero. The block drives only mode, strobe and configuration signals; the datapaths themselves sit elsewhere.

Top module: `chmr_top`

## Requirements
- R1: After reset every channel is in register mode (pkt_mode 0), all strobes are low, all configuration outputs are zero, the interrupt enable is 0 and no PHY detection is enabled.
- R2: The window of channel n starts at byte address n*0x4000. Each configuration register takes byte writes under wstrb and reads back what was written. The registers are: base pointer low word at offset 0x710, high word at 0x714, slot exponent in byte 0x718, and four thresholds in the low 16 bits of 0x800 (host up), 0x804 (host down), 0x808 (device up) and 0x80C (device down).
- R3: A write of exactly 0x00000107 to offset 0xA00 with wstrb 4'hF puts the channel into packet mode and raises run_pulse for one cycle. Any other value at that offset is ignored.
- R4: Control byte 0 sits at offset 0x900. Writing it with bit 1 set puts the channel into register mode, and bit 1 clear leaves the mode unchanged. A read of offset 0x900 returns bit 1 = 1 in register mode and 0 in packet mode; every other bit reads 0.
- R5: Bit 2 of byte 0x900 raises err_clr_pulse for that channel for one cycle. The bit is not stored and the mode does not change.
- R6: Control byte 1 sits at byte 0x901 (word bits 15:8 of offset 0x900). Its bit 1 raises link_rst_pulse for one cycle. Its bit 4 raises chan_rst_pulse for one cycle and returns the channel to register mode. Neither bit is stored.
- R7: A completion report (done_valid with done_chan = n) returns channel n to register mode. A run command written to the same channel in the same cycle wins, and the channel ends in packet mode.
- R8: Setting bit 0 of global byte 0x003 raises chip_rst_pulse for one cycle. It also returns all channels to register mode, zeroes all channel configuration, clears the interrupt enable and clears the PHY byte. The bit reads back as 0.
- R9: Bit 0 of global byte 0xE4 drives irq_en. Bit 4+n of global byte 0x393 drives phy_det_en[n]. Both bytes read back as written.
- R10: A read of global offset 0x004 returns bus64 in bit 1 and zero elsewhere, and writes there have no effect.
- R11: Read data appears on rdata one cycle after rd_en, with rvalid high for that cycle only. Unmapped or unaligned addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | 16 | Byte address, channel index in the top bits |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte write strobes |
| bus64 | input | 1 | Host bus is 64 bits wide |
| done_valid | input | 1 | Packet completion report |
| done_chan | input | 2 | Channel of the completion report |
| rdata | output | 32 | Read data |
| rvalid | output | 1 | Read data valid |
| pkt_mode | output | 4 | Per-channel packet mode (1) or register mode (0) |
| run_pulse | output | 4 | Packet start strobe |
| err_clr_pulse | output | 4 | Error clear strobe |
| link_rst_pulse | output | 4 | Link/PHY reset strobe |
| chan_rst_pulse | output | 4 | Channel logic reset strobe |
| pkt_base | output | 256 | Packet base pointer, 64 bits per channel |
| slot_exp | output | 32 | Slot size exponent, 8 bits per channel |
| thr_host_up | output | 64 | Host upstream threshold, 16 bits per channel |
| thr_host_dn | output | 64 | Host downstream threshold, 16 bits per channel |
| thr_dev_up | output | 64 | Device upstream threshold, 16 bits per channel |
| thr_dev_dn | output | 64 | Device downstream threshold, 16 bits per channel |
| chip_rst_pulse | output | 1 | Chip-wide reset strobe |
| irq_en | output | 1 | Global interrupt enable |
| phy_det_en | output | 4 | Per-channel PHY detection enable |

## Verification
The bench targets these corner cases:

- **Same-cycle race.** A completion report and a run command reach the same channel in the same cycle. A design that gave the completion priority would drop a freshly started packet back into register mode.
- **Ignored writes.** A run port is written with a wrong value, and control byte 0 is written with the mode bit clear. A design that decoded too loosely would switch modes on either write.
- **Strobes and partial writes.** The bench checks that each strobe lasts exactly one cycle and never reads back. It also checks that partial-strobe writes merge bytes, since a design that ignored wstrb would clobber neighbouring bytes.
- **Chip reset.** This must wipe every channel at once. A design that cleared only the global bytes would leave stale base pointers and packet mode behind.

// File: rtl/chmr_pkg.sv
package chmr_pkg;

    localparam int DATA_W = 32;
    localparam int OFF_W  = 12;

    // channel window word offsets
    localparam logic [OFF_W-1:0] OFS_BASE_LO = 12'h710;
    localparam logic [OFF_W-1:0] OFS_BASE_HI = 12'h714;
    localparam logic [OFF_W-1:0] OFS_SLOT    = 12'h718;
    localparam logic [OFF_W-1:0] OFS_THR_HU  = 12'h800;
    localparam logic [OFF_W-1:0] OFS_THR_HD  = 12'h804;
    localparam logic [OFF_W-1:0] OFS_THR_DU  = 12'h808;
    localparam logic [OFF_W-1:0] OFS_THR_DD  = 12'h80C;
    localparam logic [OFF_W-1:0] OFS_CTL     = 12'h900;
    localparam logic [OFF_W-1:0] OFS_CMD     = 12'hA00;

    // global word offsets (window 0)
    localparam logic [OFF_W-1:0] OFS_CHIP    = 12'h000;
    localparam logic [OFF_W-1:0] OFS_HOST    = 12'h004;
    localparam logic [OFF_W-1:0] OFS_IRQ     = 12'h0E4;
    localparam logic [OFF_W-1:0] OFS_PHY     = 12'h390;

    localparam logic [DATA_W-1:0] RUN_CMD = 32'h0000_0107;

    typedef struct packed {
        logic [63:0] base;
        logic [7:0]  slot_exp;
        logic [15:0] thr_hu;
        logic [15:0] thr_hd;
        logic [15:0] thr_du;
        logic [15:0] thr_dd;
    } chan_cfg_t;

    function automatic logic [31:0] merge32(input logic [31:0] old_v,
                                            input logic [31:0] new_v,
                                            input logic [3:0]  strb);
        logic [31:0] r;
        for (int b = 0; b < 4; b++)
            r[b*8 +: 8] = strb[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
        return r;
    endfunction

    function automatic logic [15:0] merge16(input logic [15:0] old_v,
                                            input logic [15:0] new_v,
                                            input logic [1:0]  strb);
        logic [15:0] r;
        r[7:0]  = strb[0] ? new_v[7:0]  : old_v[7:0];
        r[15:8] = strb[1] ? new_v[15:8] : old_v[15:8];
        return r;
    endfunction

endpackage

// File: rtl/chmr_chan.sv
module chmr_chan
    import chmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_rst,
    input  logic              wr_hit,
    input  logic [OFF_W-1:0]  off,
    input  logic [31:0]       wdata,
    input  logic [3:0]        wstrb,
    input  logic              done_hit,
    output logic [31:0]       rd_val,
    output chan_cfg_t         cfg,
    output logic              pkt_mode,
    output logic              run_pulse,
    output logic              err_clr,
    output logic              link_rst,
    output logic              chan_rst
);

    typedef struct packed {
        chan_cfg_t cfg;
        logic      pkt;
        logic      run;
        logic      clr;
        logic      lrst;
        logic      crst;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.run  = 1'b0;
        st_d.clr  = 1'b0;
        st_d.lrst = 1'b0;
        st_d.crst = 1'b0;

        // completion first, so a same-cycle run write overrides it
        if (done_hit)
            st_d.pkt = 1'b0;

        if (wr_hit) begin
            case (off)
                OFS_BASE_LO: st_d.cfg.base[31:0]  = merge32(st_q.cfg.base[31:0], wdata, wstrb);
                OFS_BASE_HI: st_d.cfg.base[63:32] = merge32(st_q.cfg.base[63:32], wdata, wstrb);
                OFS_SLOT: begin
                    if (wstrb[0])
                        st_d.cfg.slot_exp = wdata[7:0];
                end
                OFS_THR_HU: st_d.cfg.thr_hu = merge16(st_q.cfg.thr_hu, wdata[15:0], wstrb[1:0]);
                OFS_THR_HD: st_d.cfg.thr_hd = merge16(st_q.cfg.thr_hd, wdata[15:0], wstrb[1:0]);
                OFS_THR_DU: st_d.cfg.thr_du = merge16(st_q.cfg.thr_du, wdata[15:0], wstrb[1:0]);
                OFS_THR_DD: st_d.cfg.thr_dd = merge16(st_q.cfg.thr_dd, wdata[15:0], wstrb[1:0]);
                OFS_CTL: begin
                    if (wstrb[0]) begin
                        if (wdata[1])
                            st_d.pkt = 1'b0;
                        st_d.clr = wdata[2];
                    end
                    if (wstrb[1]) begin
                        st_d.lrst = wdata[9];
                        st_d.crst = wdata[12];
                        if (wdata[12])
                            st_d.pkt = 1'b0;
                    end
                end
                OFS_CMD: begin
                    if (wstrb == 4'hF && wdata == RUN_CMD) begin
                        st_d.pkt = 1'b1;
                        st_d.run = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (chip_rst)
            st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        rd_val = '0;
        case (off)
            OFS_BASE_LO: rd_val = st_q.cfg.base[31:0];
            OFS_BASE_HI: rd_val = st_q.cfg.base[63:32];
            OFS_SLOT:    rd_val = {24'b0, st_q.cfg.slot_exp};
            OFS_THR_HU:  rd_val = {16'b0, st_q.cfg.thr_hu};
            OFS_THR_HD:  rd_val = {16'b0, st_q.cfg.thr_hd};
            OFS_THR_DU:  rd_val = {16'b0, st_q.cfg.thr_du};
            OFS_THR_DD:  rd_val = {16'b0, st_q.cfg.thr_dd};
            OFS_CTL:     rd_val = {30'b0, ~st_q.pkt, 1'b0};
            default:     rd_val = '0;
        endcase
    end

    assign cfg       = st_q.cfg;
    assign pkt_mode  = st_q.pkt;
    assign run_pulse = st_q.run;
    assign err_clr   = st_q.clr;
    assign link_rst  = st_q.lrst;
    assign chan_rst  = st_q.crst;

endmodule

// File: rtl/chmr_glob.sv
module chmr_glob
    import chmr_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [OFF_W-1:0]  off,
    input  logic [7:0]        wbyte0,
    input  logic [7:0]        wbyte3,
    input  logic              strb0,
    input  logic              strb3,
    input  logic              bus64,
    output logic [31:0]       rd_val,
    output logic              chip_hit,
    output logic              chip_rst_pulse,
    output logic              irq_en,
    output logic [NCH-1:0]    phy_det_en
);

    typedef struct packed {
        logic [7:0] irq;
        logic [7:0] phy;
        logic       rst;
    } glob_st_t;

    glob_st_t st_d, st_q;

    always_comb begin
        chip_hit = wr_hit && (off == OFS_CHIP) && strb3 && wbyte3[0];
    end

    always_comb begin
        st_d     = st_q;
        st_d.rst = 1'b0;
        if (wr_hit) begin
            if (off == OFS_IRQ && strb0)
                st_d.irq = wbyte0;
            if (off == OFS_PHY && strb3)
                st_d.phy = wbyte3;
        end
        if (chip_hit) begin
            st_d.irq = '0;
            st_d.phy = '0;
            st_d.rst = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        rd_val = '0;
        case (off)
            OFS_HOST: rd_val = {30'b0, bus64, 1'b0};
            OFS_IRQ:  rd_val = {24'b0, st_q.irq};
            OFS_PHY:  rd_val = {st_q.phy, 24'b0};
            default:  rd_val = '0;
        endcase
    end

    assign chip_rst_pulse = st_q.rst;
    assign irq_en         = st_q.irq[0];
    assign phy_det_en     = st_q.phy[4 +: NCH];

endmodule

// File: rtl/chmr_top.sv
module chmr_top
    import chmr_pkg::*;
#(
    parameter  int NCH    = 4,
    parameter  int WIN_W  = 14,
    localparam int CH_W   = $clog2(NCH),
    localparam int ADDR_W = CH_W + WIN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    input  logic [3:0]           wstrb,
    input  logic                 bus64,
    input  logic                 done_valid,
    input  logic [CH_W-1:0]      done_chan,
    output logic [31:0]          rdata,
    output logic                 rvalid,
    output logic [NCH-1:0]       pkt_mode,
    output logic [NCH-1:0]       run_pulse,
    output logic [NCH-1:0]       err_clr_pulse,
    output logic [NCH-1:0]       link_rst_pulse,
    output logic [NCH-1:0]       chan_rst_pulse,
    output logic [NCH*64-1:0]    pkt_base,
    output logic [NCH*8-1:0]     slot_exp,
    output logic [NCH*16-1:0]    thr_host_up,
    output logic [NCH*16-1:0]    thr_host_dn,
    output logic [NCH*16-1:0]    thr_dev_up,
    output logic [NCH*16-1:0]    thr_dev_dn,
    output logic                 chip_rst_pulse,
    output logic                 irq_en,
    output logic [NCH-1:0]       phy_det_en
);

    typedef struct packed {
        logic [31:0] rdata;
        logic        rvalid;
    } rd_st_t;

    rd_st_t rs_d, rs_q;

    logic [CH_W-1:0]  ch;
    logic [OFF_W-1:0] off;
    logic             in_map;
    logic             glob_hit;
    logic             chip_hit;
    logic [31:0]      glob_rd;
    logic [31:0]      chan_rd [NCH];
    logic [31:0]      rd_mux;
    chan_cfg_t        cfg [NCH];

    always_comb begin
        ch     = addr[ADDR_W-1:WIN_W];
        off    = addr[OFF_W-1:0];
        in_map = (addr[1:0] == 2'b00) && (addr[WIN_W-1:OFF_W] == '0);
        glob_hit = wr_en && in_map && (ch == '0);
    end

    chmr_glob #(.NCH(NCH)) i_glob (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_hit         (glob_hit),
        .off            (off),
        .wbyte0         (wdata[7:0]),
        .wbyte3         (wdata[31:24]),
        .strb0          (wstrb[0]),
        .strb3          (wstrb[3]),
        .bus64          (bus64),
        .rd_val         (glob_rd),
        .chip_hit       (chip_hit),
        .chip_rst_pulse (chip_rst_pulse),
        .irq_en         (irq_en),
        .phy_det_en     (phy_det_en)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
        logic wr_hit_c;
        logic done_hit_c;

        assign wr_hit_c   = wr_en && in_map && (ch == CH_W'(gi));
        assign done_hit_c = done_valid && (done_chan == CH_W'(gi));

        chmr_chan i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .chip_rst  (chip_hit),
            .wr_hit    (wr_hit_c),
            .off       (off),
            .wdata     (wdata),
            .wstrb     (wstrb),
            .done_hit  (done_hit_c),
            .rd_val    (chan_rd[gi]),
            .cfg       (cfg[gi]),
            .pkt_mode  (pkt_mode[gi]),
            .run_pulse (run_pulse[gi]),
            .err_clr   (err_clr_pulse[gi]),
            .link_rst  (link_rst_pulse[gi]),
            .chan_rst  (chan_rst_pulse[gi])
        );

        assign pkt_base[gi*64 +: 64]    = cfg[gi].base;
        assign slot_exp[gi*8 +: 8]      = cfg[gi].slot_exp;
        assign thr_host_up[gi*16 +: 16] = cfg[gi].thr_hu;
        assign thr_host_dn[gi*16 +: 16] = cfg[gi].thr_hd;
        assign thr_dev_up[gi*16 +: 16]  = cfg[gi].thr_du;
        assign thr_dev_dn[gi*16 +: 16]  = cfg[gi].thr_dd;
    end

    always_comb begin
        rd_mux = '0;
        if (in_map) begin
            for (int i = 0; i < NCH; i++)
                if (ch == CH_W'(i))
                    rd_mux = chan_rd[i];
            if (ch == '0)
                rd_mux = rd_mux | glob_rd;
        end
    end

    always_comb begin
        rs_d        = rs_q;
        rs_d.rvalid = rd_en;
        if (rd_en)
            rs_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rs_q <= '0;
        else
            rs_q <= rs_d;
    end

    assign rdata  = rs_q.rdata;
    assign rvalid = rs_q.rvalid;

endmodule

// File: rtl/chmr_sva.sv
module chmr_sva #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            rd_en,
    input logic            rvalid,
    input logic            done_valid,
    input logic [CH_W-1:0] done_chan,
    input logic [NCH-1:0]  pkt_mode,
    input logic [NCH-1:0]  run_pulse,
    input logic [NCH-1:0]  err_clr_pulse,
    input logic [NCH-1:0]  link_rst_pulse,
    input logic [NCH-1:0]  chan_rst_pulse,
    input logic            chip_rst_pulse,
    input logic            irq_en
);

    assert_run_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_pulse != '0) |-> $past(wr_en));

    assert_pkt_entry_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pkt_mode & ~$past(pkt_mode)) != '0) |-> $past(wr_en));

    assert_clr_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_pulse != '0) |-> $past(wr_en));

    assert_rst_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_rst_pulse | chan_rst_pulse) != '0) |-> $past(wr_en));

    assert_chan_rst_reg_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_rst_pulse & pkt_mode) == '0);

    assert_done_leaves_pkt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !wr_en) |=> !pkt_mode[$past(done_chan)]);

    assert_chip_rst_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_pulse |-> (pkt_mode == '0 && !irq_en));

    assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

    assert_no_stray_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);

endmodule

bind chmr_top chmr_sva #(.NCH(NCH), .CH_W(CH_W)) i_chmr_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .rd_en          (rd_en),
    .rvalid         (rvalid),
    .done_valid     (done_valid),
    .done_chan      (done_chan),
    .pkt_mode       (pkt_mode),
    .run_pulse      (run_pulse),
    .err_clr_pulse  (err_clr_pulse),
    .link_rst_pulse (link_rst_pulse),
    .chan_rst_pulse (chan_rst_pulse),
    .chip_rst_pulse (chip_rst_pulse),
    .irq_en         (irq_en)
);

// File: tb/test_chmr_top.sv
`timescale 1ns/1ps
module test_chmr_top;

    localparam int NCH = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [15:0]       addr = '0;
    logic [31:0]       wdata = '0;
    logic [3:0]        wstrb = '0;
    logic              bus64 = 1'b1;
    logic              done_valid = 1'b0;
    logic [1:0]        done_chan = '0;
    logic [31:0]       rdata;
    logic              rvalid;
    logic [NCH-1:0]    pkt_mode, run_pulse, err_clr_pulse, link_rst_pulse, chan_rst_pulse;
    logic [NCH*64-1:0] pkt_base;
    logic [NCH*8-1:0]  slot_exp;
    logic [NCH*16-1:0] thr_host_up, thr_host_dn, thr_dev_up, thr_dev_dn;
    logic              chip_rst_pulse, irq_en;
    logic [NCH-1:0]    phy_det_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    chmr_top i_chmr_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .wstrb(wstrb), .bus64(bus64), .done_valid(done_valid),
        .done_chan(done_chan), .rdata(rdata), .rvalid(rvalid), .pkt_mode(pkt_mode),
        .run_pulse(run_pulse), .err_clr_pulse(err_clr_pulse),
        .link_rst_pulse(link_rst_pulse), .chan_rst_pulse(chan_rst_pulse),
        .pkt_base(pkt_base), .slot_exp(slot_exp), .thr_host_up(thr_host_up),
        .thr_host_dn(thr_host_dn), .thr_dev_up(thr_dev_up), .thr_dev_dn(thr_dev_dn),
        .chip_rst_pulse(chip_rst_pulse), .irq_en(irq_en), .phy_det_en(phy_det_en)
    );

    function automatic logic [15:0] ca(input int ch, input logic [15:0] off);
        return 16'(ch * 16'h4000) + off;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; wstrb = s;
        @(negedge clk);
        wr_en = 1'b0; wstrb = '0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic done(input logic [1:0] c);
        @(negedge clk);
        done_valid = 1'b1; done_chan = c;
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    // monitor: pops the scoreboard whenever read data is presented
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R11: unexpected rvalid, actual %h expected none", rdata);
            end else begin
                check(tag_q.pop_front(), {32'b0, rdata}, {32'b0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pkt_mode", 64'(pkt_mode), 64'h0);
        check("R1 strobes", 64'({run_pulse, err_clr_pulse, link_rst_pulse, chan_rst_pulse, chip_rst_pulse}), 64'h0);
        check("R1 irq/phy", 64'({irq_en, phy_det_en}), 64'h0);
        check("R1 base", 64'(pkt_base != '0), 64'h0);
        check("R1 rvalid", 64'(rvalid), 64'h0);
        rd(ca(0, 16'h0900), 32'h2, "R1 R4 ctl reads register mode");

        // R10 host info
        rd(ca(0, 16'h0004), 32'h2, "R10 bus64=1");
        wr(ca(0, 16'h0004), 32'hFFFF_FFFF, 4'hF);
        bus64 = 1'b0;
        rd(ca(0, 16'h0004), 32'h0, "R10 bus64=0, write ignored");

        // R2 configuration
        wr(ca(2, 16'h0710), 32'hDEAD_BEEF, 4'hF);
        wr(ca(2, 16'h0714), 32'h0123_4567, 4'hF);
        check("R2 base ch2", pkt_base[2*64 +: 64], 64'h0123_4567_DEAD_BEEF);
        check("R2 base ch1 untouched", pkt_base[1*64 +: 64], 64'h0);
        wr(ca(2, 16'h0710), 32'h1122_3344, 4'b0101);
        rd(ca(2, 16'h0710), 32'hDE22_BE44, "R2 partial strobe merge");
        rd(ca(2, 16'h0714), 32'h0123_4567, "R2 base hi readback");
        wr(ca(1, 16'h0800), 32'd32, 4'hF);
        wr(ca(1, 16'h0804), 32'd32, 4'hF);
        wr(ca(1, 16'h0808), 32'd10, 4'hF);
        wr(ca(1, 16'h080C), 32'd8, 4'hF);
        wr(ca(3, 16'h0718), 32'h0000_0006, 4'h1);
        check("R2 thr ch1", {thr_host_up[16 +: 16], thr_host_dn[16 +: 16], thr_dev_up[16 +: 16], thr_dev_dn[16 +: 16]},
              {16'd32, 16'd32, 16'd10, 16'd8});
        check("R2 slot ch3", 64'(slot_exp[3*8 +: 8]), 64'd6);
        rd(ca(1, 16'h0808), 32'd10, "R2 thr readback");

        // R3 run command
        wr(ca(1, 16'h0A00), 32'h0000_0107, 4'hF);
        check("R3 pkt mode ch1", 64'(pkt_mode), 64'h2);
        check("R3 run pulse", 64'(run_pulse), 64'h2);
        @(negedge clk);
        check("R3 run pulse one cycle", 64'(run_pulse), 64'h0);
        wr(ca(2, 16'h0A00), 32'h0000_0108, 4'hF);
        check("R3 wrong value ignored", 64'(pkt_mode), 64'h2);
        wr(ca(2, 16'h0A00), 32'h0000_0107, 4'h3);
        check("R3 partial strobe ignored", 64'(pkt_mode), 64'h2);
        rd(ca(1, 16'h0900), 32'h0, "R3 R4 ctl reads packet mode");

        // R4 register mode bit
        wr(ca(1, 16'h0900), 32'h0, 4'h1);
        check("R4 bit1 clear leaves mode", 64'(pkt_mode), 64'h2);
        wr(ca(1, 16'h0900), 32'h2, 4'h1);
        check("R4 bit1 set -> register mode", 64'(pkt_mode), 64'h0);

        // R5 error clear
        wr(ca(0, 16'h0A00), 32'h0000_0107, 4'hF);
        wr(ca(0, 16'h0900), 32'h4, 4'h1);
        check("R5 err clr pulse", 64'(err_clr_pulse), 64'h1);
        check("R5 mode unchanged", 64'(pkt_mode), 64'h1);
        @(negedge clk);
        check("R5 pulse one cycle", 64'(err_clr_pulse), 64'h0);
        rd(ca(0, 16'h0900), 32'h0, "R5 clear bit not stored");

        // R6 control byte 1
        wr(ca(3, 16'h0A00), 32'h0000_0107, 4'hF);
        wr(ca(3, 16'h0900), 32'h0000_1200, 4'h2);
        check("R6 link+chan rst ch3", 64'({link_rst_pulse, chan_rst_pulse}), 64'h88);
        check("R6 chan rst -> reg mode", 64'(pkt_mode), 64'h1);
        @(negedge clk);
        check("R6 pulses one cycle", 64'({link_rst_pulse, chan_rst_pulse}), 64'h0);
        wr(ca(2, 16'h0A00), 32'h0000_0107, 4'hF);
        wr(ca(2, 16'h0900), 32'h0000_0200, 4'h2);
        check("R6 link rst only", 64'({link_rst_pulse, chan_rst_pulse}), 64'h40);
        check("R6 link rst keeps mode", 64'(pkt_mode), 64'h5);
        rd(ca(2, 16'h0900), 32'h0, "R6 ctl1 not stored");

        // R7 completion
        done(2'd0);
        check("R7 done ch0", 64'(pkt_mode), 64'h4);
        done(2'd1);
        check("R7 done on reg-mode channel", 64'(pkt_mode), 64'h4);
        @(negedge clk);
        wr_en = 1'b1; addr = ca(2, 16'h0A00); wdata = 32'h0000_0107; wstrb = 4'hF;
        done_valid = 1'b1; done_chan = 2'd2;
        @(negedge clk);
        wr_en = 1'b0; done_valid = 1'b0; wstrb = '0;
        check("R7 run beats done same cycle", 64'(pkt_mode), 64'h4);
        done(2'd2);
        check("R7 done after run", 64'(pkt_mode), 64'h0);

        // R9 globals
        wr(ca(0, 16'h00E4), 32'h1, 4'h1);
        check("R9 irq enable", 64'(irq_en), 64'h1);
        wr(ca(0, 16'h0390), 32'hF000_0000, 4'h8);
        check("R9 phy all", 64'(phy_det_en), 64'hF);
        wr(ca(0, 16'h0390), 32'h3000_0000, 4'h8);
        check("R9 phy partial", 64'(phy_det_en), 64'h3);
        rd(ca(0, 16'h0390), 32'h3000_0000, "R9 phy readback");
        rd(ca(0, 16'h00E4), 32'h1, "R9 irq readback");

        // R8 chip reset
        wr(ca(1, 16'h0A00), 32'h0000_0107, 4'hF);
        wr(ca(0, 16'h0000), 32'h0, 4'h8);
        check("R8 bit clear no effect", 64'({chip_rst_pulse, irq_en}), 64'h1);
        wr(ca(0, 16'h0000), 32'h0100_0000, 4'h8);
        check("R8 chip rst pulse", 64'(chip_rst_pulse), 64'h1);
        check("R8 modes cleared", 64'(pkt_mode), 64'h0);
        check("R8 irq/phy cleared", 64'({irq_en, phy_det_en}), 64'h0);
        check("R8 base cleared", 64'(pkt_base[2*64 +: 64]), 64'h0);
        check("R8 thr cleared", 64'(thr_dev_up[16 +: 16]), 64'h0);
        @(negedge clk);
        check("R8 pulse one cycle", 64'(chip_rst_pulse), 64'h0);
        rd(ca(0, 16'h0000), 32'h0, "R8 chip bit reads 0");

        // R11 unmapped / unaligned
        rd(ca(1, 16'h0100), 32'h0, "R11 unmapped");
        wr(ca(1, 16'h0800), 32'h55, 4'hF);
        rd(ca(1, 16'h0801), 32'h0, "R11 unaligned");
        rd(ca(1, 16'h0A00), 32'h0, "R11 command port reads 0");
        @(negedge clk);
        check("R11 rvalid idle", 64'(rvalid), 64'h0);

        repeat (2) @(negedge clk);
        check("R11 scoreboard drained", 64'(exp_q.size()), 64'h0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule